// File: doc/BRIEF.md
# Keyed Boot-Entry Permission Window

This block stops runaway code from falling into the boot ROM. Software writes a 6-bit value to a key register. When the value equals a fixed key, the block opens a permission window that lasts a set number of instruction cycles and then closes by itself.

The instruction decoder reports each jump-to-boot instruction to the block. For each one, the block says whether the target is the boot ROM or the ordinary flash address. A boot entry uses up the permission. An interrupt taken while the window is open cancels it at once. While an emulation breakpoint holds the core, the window's cycle count is frozen.

The remaining-cycle count is an output, and the armed flag is simply "count is not zero".

Top module: `bootJumpGuard`

## Requirements
- R1: After reset, `armed` is 0 and `cyclesLeft` is 0.
- R2: A key write whose 6-bit data equals `KEY_VALUE` (default 6'b101101) sets `cyclesLeft` to `WINDOW` (default 8) on the next clock. `armed` is high whenever `cyclesLeft` is not zero.
- R3: A key write whose data differs from `KEY_VALUE` in any bit never sets `armed`.
- R4: While armed, each `cycleTick` without `bkptHalt` lowers `cyclesLeft` by one. The flag therefore drops after exactly `WINDOW` ticks that follow the matching write.
- R5: `bootSel` is high in the same cycle exactly when `jumpDecode` is high and `armed` is high. Otherwise `bootSel` is 0, which selects the flash target.
- R6: A jump that selects boot clears `armed` and `cyclesLeft` on the next clock. This holds even if a matching key write arrives in that same cycle.
- R7: While `bkptHalt` is high, `cycleTick` does not change `cyclesLeft`.
- R8: `irqTaken` clears `armed` and `cyclesLeft` on the next clock. It overrides a matching key write in the same cycle.
- R9: A matching key write while armed reloads `cyclesLeft` to `WINDOW`. A mismatched write while armed leaves `cyclesLeft` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyWrEn | input | 1 | Key register write strobe |
| keyWrData | input | KEY_W | Value written to the key register |
| cycleTick | input | 1 | One pulse per instruction cycle |
| jumpDecode | input | 1 | Jump-to-boot instruction decoded this cycle |
| irqTaken | input | 1 | Interrupt accepted this cycle |
| bkptHalt | input | 1 | Emulation breakpoint is holding the core |
| armed | output | 1 | Permission window is open |
| bootSel | output | 1 | 1 = jump to boot ROM, 0 = jump to flash |
| cyclesLeft | output | CNT_W | Instruction cycles left in the window |

## Verification
The hardest situations to reach are collisions inside an open window. Examples are an interrupt, a taken jump or a breakpoint landing on the same clock as a key write or a tick, and a mismatched write arriving partway through the count. The bench opens a window, runs a chosen number of ticks to reach a known count, and then applies the colliding strobes together. It sweeps every jump position from 0 to past the window length. It also sweeps all 64 key values, both with the window closed and with it open, and compares `cyclesLeft` with counts computed from the tick history.

// File: rtl/bootGuardPkg.sv
package bootGuardPkg;
  typedef struct packed {
    logic load;   // reload window to full length
    logic clear;  // close window at once
    logic dec;    // consume one instruction cycle
  } cntCmd_t;
endpackage

// File: rtl/bootGuardCtrl.sv
module bootGuardCtrl
  import bootGuardPkg::*;
#(
  parameter int KEY_W = 6,
  parameter logic [KEY_W-1:0] KEY_VALUE = 6'b101101
) (
  input  logic             keyWrEn,
  input  logic [KEY_W-1:0] keyWrData,
  input  logic             cycleTick,
  input  logic             jumpDecode,
  input  logic             irqTaken,
  input  logic             bkptHalt,
  input  logic             armed,
  output cntCmd_t          cmd,
  output logic             bootSel
);
  logic keyMatch;
  logic jumpTaken;

  assign keyMatch  = keyWrEn && (keyWrData == KEY_VALUE);
  assign jumpTaken = jumpDecode && armed;
  assign bootSel   = jumpTaken;

  // Priority: interrupt, consumed permission, key reload, tick.
  always_comb begin
    cmd = '0;
    if (irqTaken || jumpTaken) begin
      cmd.clear = 1'b1;
    end else if (keyMatch) begin
      cmd.load = 1'b1;
    end else if (armed && cycleTick && !bkptHalt) begin
      cmd.dec = 1'b1;
    end
  end
endmodule

// File: rtl/bootGuardCount.sv
module bootGuardCount
  import bootGuardPkg::*;
#(
  parameter int WINDOW = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  output logic [CNT_W-1:0] count,
  output logic             nonZero
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WINDOW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.clear) begin
      count <= '0;
    end else if (cmd.load) begin
      count <= FULL;
    end else if (cmd.dec) begin
      count <= count - 1'b1;
    end
  end

  assign nonZero = |count;
endmodule

// File: rtl/bootJumpGuard.sv
module bootJumpGuard
  import bootGuardPkg::*;
#(
  parameter int KEY_W = 6,
  parameter logic [KEY_W-1:0] KEY_VALUE = 6'b101101,
  parameter int WINDOW = 8,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyWrEn,
  input  logic [KEY_W-1:0] keyWrData,
  input  logic             cycleTick,
  input  logic             jumpDecode,
  input  logic             irqTaken,
  input  logic             bkptHalt,
  output logic             armed,
  output logic             bootSel,
  output logic [CNT_W-1:0] cyclesLeft
);
  cntCmd_t cmd;

  bootGuardCtrl #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) uCtrl (
    .keyWrEn(keyWrEn), .keyWrData(keyWrData), .cycleTick(cycleTick),
    .jumpDecode(jumpDecode), .irqTaken(irqTaken), .bkptHalt(bkptHalt),
    .armed(armed), .cmd(cmd), .bootSel(bootSel)
  );

  bootGuardCount #(.WINDOW(WINDOW), .CNT_W(CNT_W)) uCount (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .count(cyclesLeft), .nonZero(armed)
  );
endmodule

// File: rtl/bootJumpGuardChecker.sv
module bootJumpGuardChecker #(
  parameter int KEY_W = 6,
  parameter logic [KEY_W-1:0] KEY_VALUE = 6'b101101,
  parameter int WINDOW = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             keyWrEn,
  input logic [KEY_W-1:0] keyWrData,
  input logic             cycleTick,
  input logic             jumpDecode,
  input logic             irqTaken,
  input logic             bkptHalt,
  input logic             armed,
  input logic             bootSel,
  input logic [CNT_W-1:0] cyclesLeft
);
  p_match_loads_r2: assert property (@(posedge clk) disable iff (!rstN)
    keyWrEn && keyWrData == KEY_VALUE && !irqTaken && !bootSel
      |=> cyclesLeft == CNT_W'(WINDOW));

  p_mismatch_no_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    !armed && keyWrEn && keyWrData != KEY_VALUE |=> !armed);

  p_tick_decrements_r4: assert property (@(posedge clk) disable iff (!rstN)
    armed && cycleTick && !bkptHalt && !irqTaken && !keyWrEn && !jumpDecode
      |=> cyclesLeft == $past(cyclesLeft) - 1'b1);

  p_boot_needs_arm_r5: assert property (@(posedge clk) disable iff (!rstN)
    bootSel |-> armed && jumpDecode);

  p_boot_consumes_r6: assert property (@(posedge clk) disable iff (!rstN)
    bootSel |=> !armed);

  p_halt_freezes_r7: assert property (@(posedge clk) disable iff (!rstN)
    bkptHalt && !irqTaken && !keyWrEn && !jumpDecode |=> $stable(cyclesLeft));

  p_irq_cancels_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqTaken |=> !armed && cyclesLeft == '0);
endmodule

bind bootJumpGuard bootJumpGuardChecker #(
  .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE), .WINDOW(WINDOW), .CNT_W(CNT_W)
) uChecker (
  .clk(clk), .rstN(rstN), .keyWrEn(keyWrEn), .keyWrData(keyWrData),
  .cycleTick(cycleTick), .jumpDecode(jumpDecode), .irqTaken(irqTaken),
  .bkptHalt(bkptHalt), .armed(armed), .bootSel(bootSel),
  .cyclesLeft(cyclesLeft)
);

// File: tb/bootJumpGuard_test.sv
module bootJumpGuard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] KEY = 6'b101101;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyWrEn = 1'b0;
  logic [5:0] keyWrData = '0;
  logic cycleTick = 1'b0;
  logic jumpDecode = 1'b0;
  logic irqTaken = 1'b0;
  logic bkptHalt = 1'b0;
  logic armed, bootSel;
  logic [3:0] cyclesLeft;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bootJumpGuard uut (
    .clk(clk), .rstN(rstN), .keyWrEn(keyWrEn), .keyWrData(keyWrData),
    .cycleTick(cycleTick), .jumpDecode(jumpDecode), .irqTaken(irqTaken),
    .bkptHalt(bkptHalt), .armed(armed), .bootSel(bootSel),
    .cyclesLeft(cyclesLeft)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkCount(input string req, input int exp);
    check(int'(cyclesLeft) == exp && armed == (exp != 0), req, int'(cyclesLeft), exp);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic quiet();
    keyWrEn = 0; cycleTick = 0; jumpDecode = 0; irqTaken = 0; bkptHalt = 0;
  endtask

  task automatic writeKey(input logic [5:0] v);
    keyWrEn = 1; keyWrData = v; step(); keyWrEn = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cycleTick = 1; step(); cycleTick = 0;
    end
  endtask

  task automatic disarm();
    irqTaken = 1; step(); irqTaken = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errCount++;
    vecCount++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    quiet();
    step(); step();
    checkCount("R1", 0);
    check(bootSel == 0, "R1", bootSel, 0);
    rstN = 1;
    step();
    checkCount("R1", 0);

    // R2, R3: every key value from the closed state
    for (int v = 0; v < 64; v++) begin
      writeKey(6'(v));
      checkCount(v == int'(KEY) ? "R2" : "R3", v == int'(KEY) ? WIN : 0);
      disarm();
    end

    // R4, R5, R6: jump after k ticks
    for (int k = 0; k <= WIN + 1; k++) begin
      writeKey(KEY);
      ticks(k);
      checkCount("R4", (k < WIN) ? WIN - k : 0);
      jumpDecode = 1; #1;
      check(bootSel == (k < WIN), "R5", bootSel, (k < WIN) ? 1 : 0);
      step(); jumpDecode = 0;
      checkCount("R6", 0);
      disarm();
    end

    // R7: breakpoint freezes the count
    writeKey(KEY);
    ticks(3);
    bkptHalt = 1;
    ticks(6);
    checkCount("R7", WIN - 3);
    bkptHalt = 0;
    ticks(WIN - 4);
    checkCount("R7", 1);
    ticks(1);
    checkCount("R4", 0);

    // R8: interrupt cancels, and beats a matching write
    writeKey(KEY);
    ticks(2);
    irqTaken = 1; step(); irqTaken = 0;
    checkCount("R8", 0);
    writeKey(KEY);
    irqTaken = 1; keyWrEn = 1; keyWrData = KEY; step(); quiet();
    checkCount("R8", 0);
    irqTaken = 1; keyWrEn = 1; keyWrData = KEY; step(); quiet();
    checkCount("R8", 0);

    // R9: reload while armed; mismatches while armed ignored
    writeKey(KEY);
    ticks(5);
    writeKey(KEY);
    checkCount("R9", WIN);
    ticks(2);
    for (int v = 0; v < 64; v++) begin
      if (v != int'(KEY)) begin
        writeKey(6'(v));
        checkCount("R9", WIN - 2);
      end
    end
    disarm();

    // R6: taken jump beats a matching write in the same cycle
    writeKey(KEY);
    jumpDecode = 1; keyWrEn = 1; keyWrData = KEY; #1;
    check(bootSel == 1, "R5", bootSel, 1);
    step(); quiet();
    checkCount("R6", 0);

    // R5: jump while closed goes to flash
    jumpDecode = 1; #1;
    check(bootSel == 0, "R5", bootSel, 0);
    step(); quiet();
    checkCount("R5", 0);

    summary();
  end
endmodule